// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block runs beside a DRAM controller and decides when refresh cycles are due. It does not drive the memory strobes. After reset it waits out a power-up pause and holds its request low during that time. It then asks for a fixed burst of dummy refresh cycles. When the last of them is acknowledged it raises `ready_o`. From then on it owes one refresh per interval, so that all rows are covered inside the retention window.

The controller serves requests over a level handshake. While `req_o` is high, each cycle with `ack_i` high counts as one refresh done. Owed refreshes pile up in a bounded backlog, so none is lost while the controller is busy with other traffic. The controller chooses the refresh style with `ras_only_i`. In row-addressed mode the block supplies the row to refresh on `row_o`. In the mode that uses the memory's internal counter, the row output holds still.

The timing constants are worked out from the `CLK_HZ` parameter. The pause is `PAUSE_CYC = floor(CLK_HZ*PAUSE_US/1e6)+1` cycles. The refresh interval is `INTERVAL = floor(CLK_HZ*WINDOW_MS/(1000*ROWS)) - MARGIN` cycles. For 256 rows in 4 ms this gives one refresh about every 15.6 µs, less the margin.

Top module: `refresh_sched`

## Requirements
- R1: For the first PAUSE_CYC rising edges after reset is released, `req_o` and `ready_o` stay low, and `ack_i` has no effect on the init count or on `row_o`.
- R2: From the edge that ends the pause, `req_o` stays high and `ready_o` stays low until INIT_REFRESHES (8) acknowledges have been accepted.
- R3: `ready_o` rises right after the edge that accepts the 8th init acknowledge, and it stays high until the next reset.
- R4: Once ready, one refresh becomes owed every INTERVAL cycles. The first one is owed INTERVAL edges after the edge where `ready_o` rose.
- R5: In run mode `req_o` is high exactly when the backlog is nonzero. Each accepted acknowledge with no tick in the same cycle lowers the backlog by one.
- R6: The backlog saturates at BACKLOG_MAX (8). After any number of unacknowledged intervals, 8 accepted acknowledges clear it.
- R7: When an interval tick and an accepted acknowledge fall in the same cycle, the backlog keeps its value.
- R8: With `ras_only_i`=1, `row_o` grows by one on each accepted acknowledge, in both the init and run phases, and wraps from 255 to 0. With `ras_only_i`=0, `row_o` holds its value.
- R9: An acknowledge that arrives while `req_o` is low has no effect on the backlog or on `row_o`.
- R10: Asserting `rst_ni` low at once forces `ready_o` low, `req_o` low, `row_o` to 0 and the backlog to 0, and it restarts the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | One refresh served this cycle; counted only while `req_o` is high |
| ras_only_i | input | 1 | 1: row-addressed refresh style, which advances `row_o`; 0: internal-counter style |
| req_o | output | 1 | A refresh is owed |
| ready_o | output | 1 | Initialization done; normal accesses allowed |
| row_o | output | ROW_W (8) | Row to refresh in row-addressed mode |

## Verification
Two events can land on the same rising edge: the interval tick that adds an owed refresh, and an accepted acknowledge that retires one. The bench keeps its own cycle model of the interval counter. It waits until that model says the next edge carries a tick, then drives `ack_i` for exactly that edge while one refresh is already owed. The result is judged at the ports. `req_o` must still be high afterwards, and exactly one more acknowledge must bring it low. Both wrong outcomes show up this way: a dropped tick leaves `req_o` low, and a lost acknowledge needs two more acknowledges.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;
endpackage

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int PAUSE_CYC = 5001,
  parameter int INIT_ACKS = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ack_acc_i,
  output phase_e phase_o
);
  localparam int PW = (PAUSE_CYC > 1) ? $clog2(PAUSE_CYC) : 1;
  localparam int IW = (INIT_ACKS > 1) ? $clog2(INIT_ACKS) : 1;

  phase_e        phase_q;
  logic [PW-1:0] pause_q;
  logic [IW-1:0] init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      init_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_PAUSE: begin
          if (pause_q == PW'(PAUSE_CYC - 1)) phase_q <= PH_INIT;
          else                               pause_q <= pause_q + 1'b1;
        end
        PH_INIT: begin
          if (ack_acc_i) begin
            if (init_q == IW'(INIT_ACKS - 1)) phase_q <= PH_RUN;
            else                              init_q  <= init_q + 1'b1;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

  assign phase_o = phase_q;

  // R2: init phase only ends on an accepted acknowledge
  a_r2_init_waits_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INIT && !ack_acc_i) |=> phase_q == PH_INIT);
  // R3: run is terminal until reset
  a_r3_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN) |=> phase_q == PH_RUN);
endmodule

// File: rtl/rs_interval_tick.sv
module rs_interval_tick #(
  parameter int INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(INTERVAL - 1));
  assign tick_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (last)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R4: ticks never come back to back
  a_r4_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rs_backlog.sv
module rs_backlog #(
  parameter int MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ack_i,
  output logic busy_o
);
  localparam int W = $clog2(MAX + 1);

  logic [W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      unique case ({tick_i, ack_i})
        2'b10:   if (pend_q != W'(MAX)) pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0)      pend_q <= pend_q - 1'b1;
        default: ;  // idle, or tick replaces the retired refresh
      endcase
    end
  end

  assign busy_o = (pend_q != '0);

  a_r6_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= W'(MAX));
  a_r5_ack_retires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !tick_i && busy_o) |=> pend_q == $past(pend_q) - 1'b1);
  a_r7_coincide_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && tick_i) |=> $stable(pend_q));
endmodule

// File: rtl/rs_row_ctr.sv
module rs_row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (adv_i) row_o <= row_o + 1'b1;
  end

  a_r8_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> row_o == $past(row_o) + 1'b1);
  a_r8_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_o));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int WINDOW_MS      = 4,
  parameter int ROWS           = 256,
  parameter int PAUSE_US       = 100,
  parameter int INIT_REFRESHES = 8,
  parameter int BACKLOG_MAX    = 8,
  parameter int MARGIN         = 1,
  localparam int ROW_W         = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  input  logic             ras_only_i,
  output logic             req_o,
  output logic             ready_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int PAUSE_CYC =
    int'((64'(CLK_HZ) * 64'(PAUSE_US)) / 64'd1_000_000) + 1;
  localparam int INTERVAL =
    int'((64'(CLK_HZ) * 64'(WINDOW_MS)) / (64'd1000 * 64'(ROWS))) - MARGIN;

  phase_e phase;
  logic   run, tick, busy, ack_acc;

  assign run     = (phase == PH_RUN);
  assign req_o   = (phase == PH_INIT) || (run && busy);
  assign ready_o = run;
  assign ack_acc = ack_i && req_o;

  rs_phase_ctrl #(.PAUSE_CYC(PAUSE_CYC), .INIT_ACKS(INIT_REFRESHES)) u_phase (
    .clk_i, .rst_ni, .ack_acc_i(ack_acc), .phase_o(phase)
  );

  rs_interval_tick #(.INTERVAL(INTERVAL)) u_tick (
    .clk_i, .rst_ni, .en_i(run), .tick_o(tick)
  );

  rs_backlog #(.MAX(BACKLOG_MAX)) u_backlog (
    .clk_i, .rst_ni, .tick_i(tick), .ack_i(ack_acc && run), .busy_o(busy)
  );

  rs_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .adv_i(ack_acc && ras_only_i), .row_o
  );

  // R1: quiet during power-up pause
  a_r1_pause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_PAUSE) |-> (!req_o && !ready_o));
  // R3: ready only rises after an accepted acknowledge
  a_r3_ready_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(ack_i && req_o));
  a_r3_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;
  localparam int CLK_HZ   = 2_000_000;
  localparam int PAUSE    = 201;  // floor(2e6*100/1e6)+1
  localparam int INTERVAL = 30;   // floor(2e6*4/256000)-1
  localparam int BMAX     = 8;

  logic       clk_i = 1'b0, rst_ni = 1'b0, ack_i = 1'b0, ras_only_i = 1'b1;
  logic       req_o, ready_o;
  logic [7:0] row_o;

  int checks = 0, fails = 0;

  refresh_sched #(.CLK_HZ(CLK_HZ)) dut (
    .clk_i, .rst_ni, .ack_i, .ras_only_i, .req_o, .ready_o, .row_o
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  // Bench model of the run phase, from R4-R9
  bit         model_on = 1'b0;
  int         m_cnt, m_pend;
  logic [7:0] m_row;
  always @(posedge clk_i) begin
    if (model_on) begin
      bit t, a;
      t = (m_cnt == INTERVAL - 1);
      a = ack_i && (m_pend != 0);
      m_cnt = t ? 0 : m_cnt + 1;
      if (t && !a)      m_pend = (m_pend < BMAX) ? m_pend + 1 : BMAX;
      else if (a && !t) m_pend = m_pend - 1;
      if (a && ras_only_i) m_row = m_row + 8'd1;
    end
  end

  task automatic check(input string r, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    ack_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic acks(input int n);
    ack_i = 1'b1;
    repeat (n) @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  typedef struct packed {
    int idle_n;
    int ack_n;
    bit ras;
  } step_t;

  localparam step_t STEPS [9] = '{
    '{29,  0, 1'b1},  // R4: just before first tick
    '{1,   0, 1'b1},  // R4: first refresh owed
    '{0,   1, 1'b1},  // R5 R8: retire it, row steps
    '{0,   3, 1'b1},  // R9: acks while idle ignored
    '{300, 0, 1'b0},  // R6: many intervals unserved
    '{0,   7, 1'b0},  // R6 R8: still owed, row held
    '{0,   1, 1'b0},  // R6: eighth ack drains
    '{95,  2, 1'b1},
    '{40,  5, 1'b1}
  };

  initial begin
    #(20 * 150_000);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    check("R10", ready_o, 0, "ready in reset");
    check("R10", req_o,   0, "req in reset");
    check("R10", row_o,   0, "row in reset");
    rst_ni = 1'b1;

    // R1: pause, with acks thrown at it early
    for (int k = 0; k < PAUSE - 1; k++) begin
      ack_i = (k < 10);
      @(negedge clk_i);
    end
    ack_i = 1'b0;
    check("R1", req_o, 0, "req at end of pause");
    check("R1", row_o, 0, "row untouched by pause acks");
    @(negedge clk_i);
    check("R2", req_o, 1, "req after pause");

    acks(7);
    check("R2", ready_o, 0, "ready after 7 init acks");
    check("R2", req_o,   1, "req after 7 init acks");
    check("R8", row_o,   7, "row during init");
    acks(1);
    check("R3", ready_o, 1, "ready after 8th ack");
    check("R5", req_o,   0, "req with empty backlog");
    check("R8", row_o,   8, "row after init");

    m_cnt = 0; m_pend = 0; m_row = row_o; model_on = 1'b1;

    foreach (STEPS[i]) begin
      ras_only_i = STEPS[i].ras;
      idle(STEPS[i].idle_n);
      acks(STEPS[i].ack_n);
      check("R5", req_o, (m_pend != 0), $sformatf("table step %0d req", i));
      check("R8", row_o, m_row, $sformatf("table step %0d row", i));
    end
    check("R3", ready_o, 1, "ready stays high");

    // R6: saturation, drained just after a tick
    ras_only_i = 1'b1;
    idle(12 * INTERVAL);
    while (m_cnt != 0) @(negedge clk_i);
    n = 0;
    for (int i = 0; i < 20 && req_o; i++) begin
      ack_i = 1'b1; @(negedge clk_i); n++;
    end
    ack_i = 1'b0;
    check("R6", n, BMAX, "acks to drain saturated backlog");

    // R7: tick and ack on the same edge with one owed
    while (m_cnt != INTERVAL - 1) @(negedge clk_i);
    @(negedge clk_i);  // tick: one owed
    while (m_cnt != INTERVAL - 1) @(negedge clk_i);
    acks(1);            // coincides with next tick
    check("R7", req_o, 1, "req after tick+ack");
    acks(1);
    check("R7", req_o, 0, "req after one more ack");

    // R9: ack while req low
    n = row_o;
    acks(2);
    check("R9", row_o, n, "row with ack while idle");
    check("R9", req_o, 0, "req with ack while idle");

    // R8: wrap 255 -> 0
    while (m_row != 8'd255) begin
      ack_i = req_o;
      @(negedge clk_i);
    end
    ack_i = 1'b0;
    check("R8", row_o, 255, "row before wrap");
    while (!req_o) @(negedge clk_i);
    acks(1);
    check("R8", row_o, 0, "row wraps");

    // R10: reset mid-run
    idle(3 * INTERVAL);
    rst_ni = 1'b0; model_on = 1'b0;
    #1;
    check("R10", ready_o, 0, "ready on reset");
    check("R10", req_o,   0, "req on reset");
    check("R10", row_o,   0, "row on reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(5);
    check("R1", req_o, 0, "pause restarts after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule